// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM

A synchronous dual-port static memory of 2048 words of 8 bits. It has two independent access sides, left and right. Each side has its own select, write enable, output enable, address and write data, and each can read or write any word in any cycle. A read presented at a clock edge returns its word after that edge, together with a valid flag. When a side is deselected it stands by: it makes no access and releases its read data to zero.

When both sides select the same word in the same cycle, built-in contention logic picks one winner and pulls the other side's active-low busy line low. The losing side's write is dropped. Its read still completes, but it comes back marked stale. A side whose request was already standing in the previous cycle beats a newcomer. An exact tie goes to the left side. A decision holds for as long as both sides stay on that word.

A mode pin selects master or slave behaviour. A master drives its busy outputs from its own arbitration. A slave ignores its own arbitration, holds its busy outputs high, and takes the busy lines of a master as inputs. Placing a master and several slaves side by side, with the master's busy outputs wired to every slave's busy inputs, gives 16-bit or wider words. In that arrangement every byte lane drops the same losing write.

Top module: `dpram_arb_top`

## Requirements
- R1: A side that is selected (`*_sel`=1), writing (`*_wr`=1) and not busy stores `*_wdata` at `*_addr` on the clock edge. The memory holds 2048 words of 8 bits on an 11-bit address.
- R2: A side that is selected with `*_wr`=0 reads at the edge. After that edge `*_rvalid` is 1 exactly when `*_oe` was also 1, and `*_rdata` holds the word as it stood before that edge's writes. Whenever `*_rvalid` is 0, `*_rdata` is 0.
- R3: Accesses on both sides in the same cycle to different addresses complete independently and never raise busy.
- R4: In master mode (`master_mode`=1), contention exists exactly when both sides are selected with equal addresses. During contention exactly one of `l_busy_n_o`/`r_busy_n_o` is 0. Otherwise both are 1.
- R5: When contention starts, a side whose request was already present in the previous cycle (selected at the same address) wins over a side that was not.
- R6: When contention starts and both requests are equally old, the left side wins.
- R7: Once contention is decided, the same side keeps winning while both sides stay selected on that address. Contention ends when either side deselects or moves, and the next contention is decided afresh.
- R8: A busy side's write is suppressed, so the word keeps its previous contents.
- R9: A busy side's read still returns data. Its `*_rstale` is 1 with that data, and `*_rstale` is never 1 without `*_rvalid`.
- R10: In slave mode (`master_mode`=0), `l_busy_n_i`/`r_busy_n_i` (active low) alone decide which side is busy, and both `*_busy_n_o` are held at 1. If both sides write the same word in one cycle and neither is busy, the left data is kept.
- R11: A deselected side performs no write, and its `*_rvalid` is 0 after the edge.
- R12: During and right after reset, `*_rvalid`, `*_rstale` and `*_rdata` are 0, and the arbitration history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = master (own arbitration), 0 = slave (external busy) |
| l_sel | input | 1 | Left select; 0 = standby |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_busy_n_i | input | 1 | Left busy from a master, active low (slave mode) |
| l_busy_n_o | output | 1 | Left busy, active low (master mode) |
| l_rdata | output | 8 | Left read data, 0 when released |
| l_rvalid | output | 1 | Left read data driven |
| l_rstale | output | 1 | Left read made while busy |
| r_sel | input | 1 | Right select; 0 = standby |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_busy_n_i | input | 1 | Right busy from a master, active low (slave mode) |
| r_busy_n_o | output | 1 | Right busy, active low (master mode) |
| r_rdata | output | 8 | Right read data, 0 when released |
| r_rvalid | output | 1 | Right read data driven |
| r_rstale | output | 1 | Right read made while busy |

## Verification
The hardest situation to reach is the right side winning: it needs the right request standing on a word for a cycle before the left side lands on that word, and then both staying there so the held decision is tested. The stimulus parks one side on a word for a cycle, with the other side elsewhere. It then moves the other side onto that word and holds both there for several cycles, and repeats this with the roles swapped and with a simultaneous arrival. A follow-up pass reads back every contended word, so a leaked losing write shows up as wrong data.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic {
    OWN_LEFT  = 1'b0,
    OWN_RIGHT = 1'b1
  } owner_e;

  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_lose,
  output logic              r_lose
);
  logic              prev_l_sel, prev_r_sel;
  logic [ADDR_W-1:0] prev_l_addr, prev_r_addr;
  logic              hit_q;
  owner_e            owner_q;

  logic   hit, l_cont, r_cont, keep;
  owner_e owner;

  always_comb begin
    hit    = l_sel && r_sel && (l_addr == r_addr);
    l_cont = l_sel && prev_l_sel && (l_addr == prev_l_addr);
    r_cont = r_sel && prev_r_sel && (r_addr == prev_r_addr);
    keep   = hit_q && (l_addr == prev_l_addr) && (r_addr == prev_r_addr);
    if (keep)
      owner = owner_q;
    else if (r_cont && !l_cont)
      owner = OWN_RIGHT;
    else
      owner = OWN_LEFT;
    l_lose = hit && (owner == OWN_RIGHT);
    r_lose = hit && (owner == OWN_LEFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l_sel  <= 1'b0;
      prev_r_sel  <= 1'b0;
      prev_l_addr <= '0;
      prev_r_addr <= '0;
      hit_q       <= 1'b0;
      owner_q     <= OWN_LEFT;
    end else begin
      prev_l_sel  <= l_sel;
      prev_r_sel  <= r_sel;
      prev_l_addr <= l_addr;
      prev_r_addr <= r_addr;
      hit_q       <= hit;
      if (hit) owner_q <= owner;
    end
  end
endmodule

// File: rtl/dpram_storage.sv
module dpram_storage #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NPORT  = 2
) (
  input  logic                          clk,
  input  logic [NPORT-1:0]              we,
  input  logic [NPORT-1:0]              re,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
  input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
  output logic [NPORT-1:0][DATA_W-1:0]  rq
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Higher index written first so the lowest index (left side) lands last.
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (re[g]) rq[g] <= mem[addr[g]];
    end
  end
endmodule

// File: rtl/dpram_port_gate.sv
module dpram_port_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              oe,
  input  logic              busy,
  input  logic [DATA_W-1:0] raw_q,
  output logic              wr_en,
  output logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              rstale
);
  logic drive;

  assign wr_en = sel && wr && !busy;
  assign rd_en = sel && !wr;
  assign drive = rd_en && oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rstale <= 1'b0;
    end else begin
      rvalid <= drive;
      rstale <= drive && busy;
    end
  end

  assign rdata = rvalid ? raw_q : '0;
endmodule

// File: rtl/dpram_arb_top.sv
module dpram_arb_top
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_n_i,
  output logic              l_busy_n_o,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_rstale,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_n_i,
  output logic              r_busy_n_o,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_rstale
);
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0]             p_sel, p_wr, p_oe, ext_busy_n, lose_arb, lose_eff;
  logic [NPORT-1:0]             wr_en, rd_en, p_rvalid, p_rstale;
  logic [NPORT-1:0][ADDR_W-1:0] p_addr;
  logic [NPORT-1:0][DATA_W-1:0] p_wdata, raw_q, p_rdata;

  assign p_sel      = {r_sel, l_sel};
  assign p_wr       = {r_wr, l_wr};
  assign p_oe       = {r_oe, l_oe};
  assign ext_busy_n = {r_busy_n_i, l_busy_n_i};
  assign p_addr     = {r_addr, l_addr};
  assign p_wdata    = {r_wdata, l_wdata};

  dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_sel  (l_sel),
    .l_addr (l_addr),
    .r_sel  (r_sel),
    .r_addr (r_addr),
    .l_lose (lose_arb[SIDE_L]),
    .r_lose (lose_arb[SIDE_R])
  );

  // Master trusts its own arbitration; slave obeys the external busy lines.
  assign lose_eff   = master_mode ? lose_arb : ~ext_busy_n;
  assign l_busy_n_o = master_mode ? ~lose_arb[SIDE_L] : 1'b1;
  assign r_busy_n_o = master_mode ? ~lose_arb[SIDE_R] : 1'b1;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpram_port_gate #(.DATA_W(DATA_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (p_sel[g]),
      .wr     (p_wr[g]),
      .oe     (p_oe[g]),
      .busy   (lose_eff[g]),
      .raw_q  (raw_q[g]),
      .wr_en  (wr_en[g]),
      .rd_en  (rd_en[g]),
      .rdata  (p_rdata[g]),
      .rvalid (p_rvalid[g]),
      .rstale (p_rstale[g])
    );
  end

  dpram_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NPORT)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .re    (rd_en),
    .addr  (p_addr),
    .wdata (p_wdata),
    .rq    (raw_q)
  );

  assign l_rdata  = p_rdata[SIDE_L];
  assign r_rdata  = p_rdata[SIDE_R];
  assign l_rvalid = p_rvalid[SIDE_L];
  assign r_rvalid = p_rvalid[SIDE_R];
  assign l_rstale = p_rstale[SIDE_L];
  assign r_rstale = p_rstale[SIDE_R];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_sel,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_n_o,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_rstale,
  input logic              r_sel,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_n_o,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_rstale
);
  logic hit;
  assign hit = l_sel && r_sel && (l_addr == r_addr);

  a_r4_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit) |-> ($countones({~l_busy_n_o, ~r_busy_n_o}) == 1));

  a_r4_quiet_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !hit) |-> (l_busy_n_o && r_busy_n_o));

  a_r10_slave_outputs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n_o && r_busy_n_o));

  a_r7_left_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && !l_busy_n_o) |=>
      (!(master_mode && hit && (l_addr == $past(l_addr))) || !l_busy_n_o));

  a_r7_right_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && !r_busy_n_o) |=>
      (!(master_mode && hit && (r_addr == $past(r_addr))) || !r_busy_n_o));

  a_r11_left_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !l_sel |=> !l_rvalid);

  a_r11_right_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !r_sel |=> !r_rvalid);

  a_r2_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((!l_rvalid -> l_rdata == '0) && (!r_rvalid -> r_rdata == '0)));

  a_r9_stale_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_rstale -> l_rvalid) && (r_rstale -> r_rvalid)));
endmodule

bind dpram_arb_top dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_mode (master_mode),
  .l_sel       (l_sel),
  .l_addr      (l_addr),
  .l_busy_n_o  (l_busy_n_o),
  .l_rdata     (l_rdata),
  .l_rvalid    (l_rvalid),
  .l_rstale    (l_rstale),
  .r_sel       (r_sel),
  .r_addr      (r_addr),
  .r_busy_n_o  (r_busy_n_o),
  .r_rdata     (r_rdata),
  .r_rvalid    (r_rvalid),
  .r_rstale    (r_rstale)
);

// File: tb/dpram_arb_top_tb.sv
`timescale 1ns/1ps
module dpram_arb_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_mode = 1'b1;
  logic        l_sel = 0, l_wr = 0, l_oe = 0, l_busy_n_i = 1;
  logic        r_sel = 0, r_wr = 0, r_oe = 0, r_busy_n_i = 1;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic        l_busy_n_o, r_busy_n_o, l_rvalid, r_rvalid, l_rstale, r_rstale;
  logic [7:0]  l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dpram_arb_top u_dut (.*);

  // Reference model state
  logic [7:0]  m_mem [2048];
  bit          m_known [2048];
  bit          m_pls = 0, m_prs = 0, m_hitq = 0, m_ownr = 0;
  int          m_pla = 0, m_pra = 0;
  bit          e_lv = 0, e_rv = 0, e_ls = 0, e_rs = 0, e_lk = 0, e_rk = 0;
  logic [7:0]  e_ld = 0, e_rd = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag,
                     input bit ls, input bit lw, input bit lo, input int la, input int ld,
                     input bit rs, input bit rw, input bit ro, input int ra, input int rd);
    bit hit, lc, rc, ownr, lbusy, rbusy;
    @(negedge clk);
    l_sel = ls; l_wr = lw; l_oe = lo; l_addr = la[10:0]; l_wdata = ld[7:0];
    r_sel = rs; r_wr = rw; r_oe = ro; r_addr = ra[10:0]; r_wdata = rd[7:0];
    // Expected arbitration from the requirements (R4-R7, R10)
    hit = ls && rs && (la == ra);
    lc  = ls && m_pls && (la == m_pla);
    rc  = rs && m_prs && (ra == m_pra);
    if (m_hitq && la == m_pla && ra == m_pra) ownr = m_ownr;
    else ownr = (rc && !lc);
    if (master_mode) begin
      lbusy = hit && ownr;
      rbusy = hit && !ownr;
    end else begin
      lbusy = !l_busy_n_i;
      rbusy = !r_busy_n_i;
    end
    #2;
    chk({tag, " busy_l"}, l_busy_n_o, master_mode ? !lbusy : 1'b1);
    chk({tag, " busy_r"}, r_busy_n_o, master_mode ? !rbusy : 1'b1);
    @(posedge clk);
    // Expected read results use memory contents before this edge's writes (R2)
    e_lv = ls && !lw && lo; e_ls = e_lv && lbusy;
    e_rv = rs && !rw && ro; e_rs = e_rv && rbusy;
    e_lk = m_known[la]; e_ld = m_mem[la];
    e_rk = m_known[ra]; e_rd = m_mem[ra];
    if (rs && rw && !rbusy) begin m_mem[ra] = rd[7:0]; m_known[ra] = 1; end
    if (ls && lw && !lbusy) begin m_mem[la] = ld[7:0]; m_known[la] = 1; end
    m_pls = ls; m_prs = rs; m_pla = la; m_pra = ra;
    m_hitq = hit;
    if (hit) m_ownr = ownr;
    #2;
    chk({tag, " rvalid_l"}, l_rvalid, e_lv);
    chk({tag, " rvalid_r"}, r_rvalid, e_rv);
    chk({tag, " rstale_l"}, l_rstale, e_ls);
    chk({tag, " rstale_r"}, r_rstale, e_rs);
    if (!e_lv) chk({tag, " rdata_l released"}, l_rdata, 0);
    else if (e_lk) chk({tag, " rdata_l"}, l_rdata, e_ld);
    if (!e_rv) chk({tag, " rdata_r released"}, r_rdata, 0);
    else if (e_rk) chk({tag, " rdata_r"}, r_rdata, e_rd);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0,0,0,0,0, 0,0,0,0,0);
  endtask

  initial begin
    #(20.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) m_known[i] = 0;
    // R12: reset state
    repeat (3) @(posedge clk);
    #5;
    chk("R12 rvalid_l in reset", l_rvalid, 0);
    chk("R12 rvalid_r in reset", r_rvalid, 0);
    chk("R12 rstale_l in reset", l_rstale, 0);
    chk("R12 rdata_l in reset", l_rdata, 0);
    chk("R12 rdata_r in reset", r_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    idle("R12 after reset");

    // R1 R3: independent writes, then crossed reads
    for (int i = 0; i < 16; i++) cyc("R1 R3 write", 1,1,1,i,8'h40+i, 1,1,1,100+i,8'hC0+i);
    for (int i = 0; i < 16; i++) cyc("R2 R3 read", 1,0,1,100+i,0, 1,0,1,i,0);
    // R2: read-before-write at the same edge, other side writing a different word
    cyc("R2 read first", 1,0,1,5,0, 1,1,1,6,8'h99);
    // R2: output enable low releases data
    cyc("R2 oe low", 1,0,0,3,0, 1,0,0,103,0);
    // R11: standby side does not write
    cyc("R11 standby", 0,1,1,7,8'hFF, 0,1,1,107,8'hEE);
    cyc("R11 readback", 1,0,1,7,0, 1,0,1,107,0);

    // R5: left request earlier wins; R7 hold; R8 right write suppressed
    cyc("R5 left parks", 1,1,1,20,8'h11, 1,0,1,50,0);
    cyc("R5 right arrives", 1,1,1,20,8'hAA, 1,1,1,20,8'hBB);
    cyc("R7 hold", 1,1,1,20,8'hAB, 1,1,1,20,8'hBC);
    cyc("R9 loser read stale", 1,1,1,20,8'hAC, 1,0,1,20,0);
    cyc("R7 release by deselect", 0,0,0,20,0, 1,0,1,20,0);
    // R5: right request earlier wins; R8 left write suppressed
    cyc("R5 right parks", 1,0,1,60,0, 1,1,1,21,8'h22);
    cyc("R5 left arrives", 1,1,1,21,8'h33, 1,1,1,21,8'h44);
    cyc("R7 right holds", 1,1,1,21,8'h35, 1,1,1,21,8'h45);
    cyc("R9 left stale read", 1,0,1,21,0, 1,1,1,21,8'h46);
    cyc("R7 held with oe low", 1,0,0,21,0, 1,1,1,21,8'h47);
    // R7: right moves away, then comes back: fresh decision, left now older
    cyc("R7 right moves", 1,1,1,21,8'h55, 1,0,1,22,0);
    cyc("R5 R7 fresh decision", 1,1,1,21,8'h56, 1,1,1,21,8'h66);
    idle("R7 idle");
    // R6: exact tie goes left
    cyc("R6 tie", 1,1,1,30,8'h77, 1,1,1,30,8'h88);
    cyc("R6 tie hold", 1,0,1,30,0, 1,0,1,30,0);
    idle("R6 idle");
    cyc("R6 tie reads", 1,0,1,30,0, 1,0,1,30,0);
    idle("R6 idle2");
    // R8: read back contended words
    cyc("R8 readback", 1,0,1,20,0, 1,0,1,21,0);
    cyc("R8 readback2", 1,0,1,30,0, 1,0,1,20,0);

    // R10: slave mode with external busy
    master_mode = 1'b0;
    r_busy_n_i = 1'b0;
    cyc("R10 right blocked", 1,1,1,200,8'h12, 1,1,1,201,8'h34);
    cyc("R10 same word right blocked", 1,1,1,202,8'h56, 1,1,1,202,8'h78);
    r_busy_n_i = 1'b1; l_busy_n_i = 1'b0;
    cyc("R10 left blocked stale read", 1,1,1,203,8'h9A, 1,1,1,204,8'hBC);
    cyc("R10 R9 left busy read", 1,0,1,204,0, 1,0,1,203,0);
    l_busy_n_i = 1'b1;
    cyc("R10 both write same word", 1,1,1,210,8'h5A, 1,1,1,210,8'hA5);
    cyc("R10 readback", 1,0,1,201,0, 1,0,1,210,0);
    cyc("R10 readback2", 1,0,1,202,0, 1,0,1,200,0);
    idle("R10 idle");
    master_mode = 1'b1;
    idle("R4 back to master");
    cyc("R4 no contention diff addr", 1,0,1,210,0, 1,0,1,202,0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule